// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wakeup Detection

This block decides which clocks run in a small controller. Software sets one of two request bits to ask for a lower-power state. The idle request stops only the processor clock. The timers, serial port, framing logic and interrupt logic keep their clocks, so a pending interrupt can bring the processor back. The power-down request also stops the oscillator. While the oscillator is off, the address-latch strobe and the program-store strobe are held high so that external memory stays deselected.

The block leaves power-down when a reset occurs, when an enabled external interrupt pin shows an edge in its selected direction, or when the two wakeup port pins equal their compare value. Pin edges are not filtered, so a single-cycle glitch is enough to wake the block. Leaving power-down first turns the oscillator back on. The internal clocks are released only after a fixed number of good oscillator pulses has been counted.

An activity flag holds off any sleep request until the flag is cleared by a read of its register. The block runs on an always-on reference clock that is separate from the gated clocks it controls.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the block is in run: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, `ale_force` and `psen_force` are 0, and both request bits are cleared.
- R2: A write with `mode_wdata[0]`=1 in run enters idle two clock edges after the write cycle. In idle `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R3: In idle, `irq_req`=1 returns the block to run at the next edge and clears the request bits, so the block does not re-enter idle.
- R4: A write with `mode_wdata[1]`=1 enters power-down two edges after the write cycle. In power-down `osc_en`, `cpu_clk_en` and `per_clk_en` are 0, and `ale_force` and `psen_force` are 1.
- R5: When both request bits are set, power-down is entered rather than idle. Both bits are cleared on the return to run.
- R6: In power-down, pin i wakes the block only if `int_en[i]`=1 and the pin shows a falling edge (`int_pol[i]`=0) or a rising edge (`int_pol[i]`=1). The edge may last a single cycle. Disabled pins and edges in the other direction are ignored.
- R7: In power-down, `wk_port` equal to `wk_cmp` wakes the block.
- R8: After a wakeup, `osc_en` returns to 1 at the next edge. The strobes stay forced and the clocks stay gated until the edge that samples the third `osc_pulse`. The next cycle is run.
- R9: While the activity flag (set by `act_set`, cleared by `act_rd`) is 1, a pending request does not take effect. Entry happens one edge after the clearing read.
- R10: Asserting `rst_n` low during power-down immediately returns the block to run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the request bits |
| mode_wdata | input | 2 | Request bits to set: bit 0 idle, bit 1 power-down |
| irq_req | input | 1 | Unmasked interrupt request |
| act_set | input | 1 | Sets the activity flag |
| act_rd | input | 1 | Read of the activity register; clears the flag |
| ext_int | input | 3 | External interrupt pins |
| int_pol | input | 3 | Per-pin edge direction: 0 falling, 1 rising |
| int_en | input | 3 | Per-pin wakeup enable |
| wk_port | input | 2 | Wakeup port pins |
| wk_cmp | input | 2 | Wakeup port compare value |
| osc_pulse | input | 1 | One good oscillator pulse seen this cycle |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ale_force | output | 1 | Holds the address-latch strobe high |
| psen_force | output | 1 | Holds the program-store strobe high |

## Verification
The bench wakes the block with one-cycle pin glitches in each polarity. It also checks that a disabled pin, or an edge in the wrong direction, leaves the oscillator off. A detector that reacted to levels or to both edges would wake too early. It counts oscillator pulses one at a time, so a counter that is off by one would release the clocks after the second pulse. It sets both request bits together, sleeps with the activity flag pending, and then checks that the block stays in run after each wakeup. A design that left a request bit set would drop straight back into sleep.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_START = 2'd3
  } pm_state_t;

  // Edge of interest: falling when pol is 0, rising when pol is 1.
  function automatic logic edge_seen(input logic prev, input logic now, input logic pol);
    return pol ? (!prev && now) : (prev && !now);
  endfunction

  // Power-down wins over idle when both requests are pending.
  function automatic pm_state_t sleep_target(input logic [1:0] req);
    if (req[1])      return ST_PDOWN;
    else if (req[0]) return ST_IDLE;
    else             return ST_RUN;
  endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwrmode_pkg::*;
#(
  parameter int N_EXT  = 3,
  parameter int N_PORT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  pins,
  input  logic [N_EXT-1:0]  pol,
  input  logic [N_EXT-1:0]  en,
  input  logic [N_PORT-1:0] port,
  input  logic [N_PORT-1:0] cmp,
  output logic [N_EXT-1:0]  hit,
  output logic              match,
  output logic              wake_evt
);

  logic [N_EXT-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pins;
  end

  for (genvar i = 0; i < N_EXT; i++) begin : g_pin
    assign hit[i] = en[i] && edge_seen(prev_q[i], pins[i], pol[i]);

    // R6: a detected edge always leaves the pin at its selected level
    a_r6_hit_level: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |-> (pins[i] == pol[i]));
  end

  assign match    = (port == cmp);
  assign wake_evt = (|hit) || match;

endmodule

// File: rtl/pwr_osc_count.sv
module pwr_osc_count #(
  parameter int OSC_GOOD = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        active,
  input  logic                        pulse,
  output logic [$clog2(OSC_GOOD+1)-1:0] seen,
  output logic                        done
);

  localparam int CW = $clog2(OSC_GOOD + 1);
  localparam logic [CW-1:0] LAST = CW'(OSC_GOOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen <= '0;
    else if (!active || done)  seen <= '0;
    else if (pulse)            seen <= seen + 1'b1;
  end

  assign done = active && pulse && (seen == LAST);

  // R8: the count never passes the release threshold
  a_r8_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    seen <= LAST);

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int N_EXT    = 3,
  parameter int N_PORT   = 2,
  parameter int OSC_GOOD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic              irq_req,
  input  logic              act_set,
  input  logic              act_rd,
  input  logic [N_EXT-1:0]  ext_int,
  input  logic [N_EXT-1:0]  int_pol,
  input  logic [N_EXT-1:0]  int_en,
  input  logic [N_PORT-1:0] wk_port,
  input  logic [N_PORT-1:0] wk_cmp,
  input  logic              osc_pulse,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              ale_force,
  output logic              psen_force
);

  localparam int CW = $clog2(OSC_GOOD + 1);

  pm_state_t        state_q, state_d;
  logic [1:0]       req_q;
  logic             act_q;
  logic [N_EXT-1:0] pin_hit;
  logic             port_match;
  logic             wake_evt;
  logic [CW-1:0]    pulses_seen;
  logic             osc_ready;
  logic             go_run;
  logic             in_start;

  pwr_wake_detect #(.N_EXT(N_EXT), .N_PORT(N_PORT)) u_wake (
    .clk(clk), .rst_n(rst_n), .pins(ext_int), .pol(int_pol), .en(int_en),
    .port(wk_port), .cmp(wk_cmp), .hit(pin_hit), .match(port_match),
    .wake_evt(wake_evt)
  );

  assign in_start = (state_q == ST_START);

  pwr_osc_count #(.OSC_GOOD(OSC_GOOD)) u_cnt (
    .clk(clk), .rst_n(rst_n), .active(in_start), .pulse(osc_pulse),
    .seen(pulses_seen), .done(osc_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= 1'b0;
    else if (act_set) act_q <= 1'b1;
    else if (act_rd)  act_q <= 1'b0;
  end

  assign go_run = ((state_q == ST_IDLE) && irq_req) || osc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               req_q <= '0;
    else if (go_run)                          req_q <= '0;
    else if (mode_wr && state_q == ST_RUN)    req_q <= req_q | mode_wdata;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (!act_q) state_d = sleep_target(req_q);
      ST_IDLE:  if (irq_req) state_d = ST_RUN;
      ST_PDOWN: if (wake_evt) state_d = ST_START;
      ST_START: if (osc_ready) state_d = ST_RUN;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign cpu_clk_en = (state_q == ST_RUN);
  assign per_clk_en = (state_q == ST_RUN) || (state_q == ST_IDLE);
  assign osc_en     = (state_q != ST_PDOWN);
  assign ale_force  = (state_q == ST_PDOWN) || in_start;
  assign psen_force = ale_force;

  // R9: a pending activity flag holds the block in run
  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && act_q) |=> (state_q == ST_RUN));

  // R3: an interrupt in idle restores the processor clock next cycle
  a_r3_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && irq_req) |=> cpu_clk_en);

  // R6 R7: power-down is left only after a detected wake event
  a_r6_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDOWN && !wake_evt) |=> !osc_en);

  // R8: clocks are released only on the last counted pulse
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (in_start && !(osc_pulse && pulses_seen == CW'(OSC_GOOD - 1))) |=> !cpu_clk_en);

  // R4: strobes are forced whenever the oscillator is stopped
  a_r4_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (ale_force && psen_force && !per_clk_en));

endmodule

// File: tb/pwrmode_ctrl_tb.sv
module pwrmode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic irq_req = 1'b0, act_set = 1'b0, act_rd = 1'b0;
  logic [2:0] ext_int = 3'b111, int_pol = 3'b000, int_en = 3'b000;
  logic [1:0] wk_port = 2'b00, wk_cmp = 2'b11;
  logic osc_pulse = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, ale_force, psen_force;

  int checks = 0;
  int errors = 0;

  pwrmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq_req(irq_req), .act_set(act_set), .act_rd(act_rd),
    .ext_int(ext_int), .int_pol(int_pol), .int_en(int_en),
    .wk_port(wk_port), .wk_cmp(wk_cmp), .osc_pulse(osc_pulse),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .ale_force(ale_force), .psen_force(psen_force)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // outputs packed as {cpu, per, osc, ale, psen}
  task automatic expect_out(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {cpu_clk_en, per_clk_en, osc_en, ale_force, psen_force};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  localparam logic [4:0] O_RUN   = 5'b11100;
  localparam logic [4:0] O_IDLE  = 5'b01100;
  localparam logic [4:0] O_PDOWN = 5'b00011;
  localparam logic [4:0] O_START = 5'b00111;

  task automatic write_req(input logic [1:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0; mode_wdata = 2'b00;
    @(negedge clk);
  endtask

  task automatic give_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      osc_pulse = 1'b1; @(negedge clk);
      osc_pulse = 1'b0; @(negedge clk);
    end
  endtask

  task automatic finish_restart(input string req);
    give_pulses(2);
    expect_out(req, O_START);
    give_pulses(1);
    expect_out(req, O_RUN);
    repeat (3) @(negedge clk);
    expect_out(req, O_RUN);
  endtask

  task automatic t_reset;
    expect_out("R1", O_RUN);
    repeat (3) @(negedge clk);
    expect_out("R1", O_RUN);
  endtask

  task automatic t_idle;
    write_req(2'b01);
    expect_out("R2", O_IDLE);
    repeat (3) @(negedge clk);
    expect_out("R2", O_IDLE);
    irq_req = 1'b1; @(negedge clk);
    irq_req = 1'b0;
    expect_out("R3", O_RUN);
    repeat (3) @(negedge clk);
    expect_out("R3", O_RUN);
  endtask

  task automatic t_edge_wake;
    int_en = 3'b001; int_pol = 3'b000;
    write_req(2'b10);
    expect_out("R4", O_PDOWN);
    ext_int = 3'b101; @(negedge clk);
    ext_int = 3'b111; @(negedge clk);
    expect_out("R6", O_PDOWN);
    ext_int = 3'b110; @(negedge clk);
    ext_int = 3'b111;
    expect_out("R8", O_START);
    finish_restart("R8");
  endtask

  task automatic t_rising_wake;
    int_en = 3'b100; int_pol = 3'b100;
    write_req(2'b10);
    expect_out("R4", O_PDOWN);
    ext_int = 3'b011; @(negedge clk);
    expect_out("R6", O_PDOWN);
    ext_int = 3'b111; @(negedge clk);
    expect_out("R6", O_START);
    finish_restart("R6");
    int_en = 3'b000; int_pol = 3'b000;
  endtask

  task automatic t_port_wake;
    wk_cmp = 2'b10; wk_port = 2'b00;
    write_req(2'b11);
    expect_out("R5", O_PDOWN);
    irq_req = 1'b1; @(negedge clk);
    irq_req = 1'b0;
    expect_out("R7", O_PDOWN);
    wk_port = 2'b10; @(negedge clk);
    wk_port = 2'b00;
    expect_out("R7", O_START);
    finish_restart("R5");
  endtask

  task automatic t_activity;
    act_set = 1'b1; @(negedge clk);
    act_set = 1'b0;
    write_req(2'b01);
    repeat (3) @(negedge clk);
    expect_out("R9", O_RUN);
    act_rd = 1'b1; @(negedge clk);
    act_rd = 1'b0; @(negedge clk);
    expect_out("R9", O_IDLE);
    irq_req = 1'b1; @(negedge clk);
    irq_req = 1'b0;
    expect_out("R9", O_RUN);
  endtask

  task automatic t_reset_pdown;
    write_req(2'b10);
    expect_out("R10", O_PDOWN);
    rst_n = 1'b0; #1;
    expect_out("R10", O_RUN);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    expect_out("R10", O_RUN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_edge_wake();
    t_rising_wake();
    t_port_wake();
    t_activity();
    t_reset_pdown();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule